// File: doc/BRIEF.md
# Microprogram Sequencer With Branching

This block is the sequencing half of a microprogrammed control unit. A microprogram counter addresses an internal control store of 64 words, and the word it selects drives the datapath control lines directly, one line per bit. The same word carries sequencing fields: a conditional-branch flag, a condition selector with a polarity bit, a branch target, an End flag and a wait-for-memory flag. A starting-and-branch address generator turns the instruction opcode into the address of its microroutine when the datapath reports that a new instruction has been loaded. It also resolves microbranches against the negative flag, an external input or the memory-complete input.

The store holds a fetch routine at words 0 to 2 and four microroutines. These are a memory-operand add, an unconditional branch, a branch-on-negative and a spin on an external condition. Every word that was never given contents is flagged as an error while the counter points at it.

Top module: `microseq_ctrl`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, upc is 0, uerr is 0 and ctrl bit 3 (operand-A select, 1 = constant 4, 0 = register Y) is 1.
- R2: When no other rule applies, upc advances by one on each clock edge and wraps from 63 to 0.
- R3: Words 1 and 4 request wait-for-memory. While such a word is current and mfc is low, upc holds. With mfc high it advances.
- R4: ir_load high loads the microroutine start address for opcode at the next edge: opcode 0 gives 3, opcode 1 gives 20, opcode 2 gives 25 and opcode 3 gives 30.
- R5: A microbranch whose condition is met loads its target. Word 2 branches unconditionally to itself, so the fetch routine parks at word 2 until ir_load.
- R6: Word 25 goes to 0 when n_flag is 0 and to 26 when n_flag is 1. From 26 the sequence runs to 27 and then to 0.
- R7: Word 30 branches to itself while ext_cond is 0. With ext_cond at 1 it moves to 31 and then to 0.
- R8: The End words 6, 21, 27 and 31 return upc to 0 at the next edge.
- R9: When several rules apply, the order from highest to lowest is End, ir_load, taken branch, memory wait, increment.
- R10: Opcodes 4 to 15 map to word 63, which has no contents. uerr is high exactly while upc points at a word without contents. These are every word except 0-6, 20, 21, 25-27, 30 and 31.
- R11: ctrl bit 3 is 1 in word 0 and 0 in words 5, 20 and 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_load | input | 1 | A new instruction has been loaded |
| opcode | input | 4 | Opcode of the instruction being loaded |
| mfc | input | 1 | Memory operation complete |
| n_flag | input | 1 | Negative condition-code flag |
| ext_cond | input | 1 | External condition input |
| ctrl | output | 16 | Datapath control lines of the current word |
| upc | output | 6 | Microprogram counter |
| uerr | output | 1 | Current word has no contents |

## Verification
The counter is the only register. upc therefore reflects a given set of inputs one clock edge later, and ctrl and uerr follow from upc within the same cycle. The bench changes inputs on the falling edge and advances its behavioural model on the rising edge. It compares upc, uerr and the select bit on the next falling edge, so each result is checked in the cycle in which it is due. Priority cases are produced by pulsing ir_load exactly while the model sits on an End word, a waiting word or a branch word.

// File: rtl/microseq_ctrl.sv
module microseq_ctrl #(
  parameter int UA_W   = 6,
  parameter int OPC_W  = 4,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_load,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              mfc,
  input  logic              n_flag,
  input  logic              ext_cond,
  output logic [CTRL_W-1:0] ctrl,
  output logic [UA_W-1:0]   upc,
  output logic              uerr
);
  localparam int B_PCOUT = 0, B_MARIN = 1, B_READ = 2, B_SEL = 3;
  localparam int B_ADD = 4, B_ZIN = 5, B_ZOUT = 6, B_PCIN = 7;
  localparam int B_YIN = 8, B_MDROUT = 9, B_IRIN = 10, B_R1OUT = 11;
  localparam int B_R1IN = 12, B_R3OUT = 13, B_OFFOUT = 14;
  localparam logic [1:0] C_ALW = 2'd0, C_NEG = 2'd1, C_EXT = 2'd2, C_MFC = 2'd3;
  localparam int A_ADD = 3, A_BR = 20, A_BN = 25, A_SPIN = 30;
  localparam int A_BAD = (1 << UA_W) - 1;

  logic [UA_W-1:0]   upc_q, nxt, start_a, cw_tgt;
  logic [CTRL_W-1:0] cw_ctrl;
  logic [1:0]        cw_sel;
  logic              cw_br, cw_inv, cw_end, cw_wait, cw_ok;
  logic              cond_v, br_take, hold;

  always_comb begin
    cw_ctrl = '0;
    cw_br   = 1'b0;
    cw_inv  = 1'b0;
    cw_sel  = C_ALW;
    cw_tgt  = '0;
    cw_end  = 1'b0;
    cw_wait = 1'b0;
    cw_ok   = 1'b1;
    case (upc_q)
      UA_W'(0): begin
        cw_ctrl[B_PCOUT] = 1'b1; cw_ctrl[B_MARIN] = 1'b1; cw_ctrl[B_READ] = 1'b1;
        cw_ctrl[B_SEL]   = 1'b1; cw_ctrl[B_ADD]   = 1'b1; cw_ctrl[B_ZIN]  = 1'b1;
      end
      UA_W'(1): begin
        cw_ctrl[B_ZOUT] = 1'b1; cw_ctrl[B_PCIN] = 1'b1; cw_ctrl[B_YIN] = 1'b1;
        cw_wait = 1'b1;
      end
      UA_W'(2): begin
        cw_ctrl[B_MDROUT] = 1'b1; cw_ctrl[B_IRIN] = 1'b1;
        cw_br = 1'b1; cw_sel = C_ALW; cw_tgt = UA_W'(2);
      end
      UA_W'(3): begin
        cw_ctrl[B_R3OUT] = 1'b1; cw_ctrl[B_MARIN] = 1'b1; cw_ctrl[B_READ] = 1'b1;
      end
      UA_W'(4): begin
        cw_ctrl[B_R1OUT] = 1'b1; cw_ctrl[B_YIN] = 1'b1;
        cw_wait = 1'b1;
      end
      UA_W'(5): begin
        cw_ctrl[B_MDROUT] = 1'b1; cw_ctrl[B_ADD] = 1'b1; cw_ctrl[B_ZIN] = 1'b1;
      end
      UA_W'(6): begin
        cw_ctrl[B_ZOUT] = 1'b1; cw_ctrl[B_R1IN] = 1'b1;
        cw_end = 1'b1;
      end
      UA_W'(20), UA_W'(26): begin
        cw_ctrl[B_OFFOUT] = 1'b1; cw_ctrl[B_ADD] = 1'b1; cw_ctrl[B_ZIN] = 1'b1;
      end
      UA_W'(21), UA_W'(27): begin
        cw_ctrl[B_ZOUT] = 1'b1; cw_ctrl[B_PCIN] = 1'b1;
        cw_end = 1'b1;
      end
      UA_W'(25): begin
        cw_br = 1'b1; cw_sel = C_NEG; cw_inv = 1'b1; cw_tgt = '0;
      end
      UA_W'(30): begin
        cw_br = 1'b1; cw_sel = C_EXT; cw_inv = 1'b1; cw_tgt = UA_W'(A_SPIN);
      end
      UA_W'(31): cw_end = 1'b1;
      default:   cw_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (opcode)
      OPC_W'(0): start_a = UA_W'(A_ADD);
      OPC_W'(1): start_a = UA_W'(A_BR);
      OPC_W'(2): start_a = UA_W'(A_BN);
      OPC_W'(3): start_a = UA_W'(A_SPIN);
      default:   start_a = UA_W'(A_BAD);
    endcase
  end

  always_comb begin
    case (cw_sel)
      C_ALW:   cond_v = 1'b1;
      C_NEG:   cond_v = n_flag;
      C_EXT:   cond_v = ext_cond;
      default: cond_v = mfc;
    endcase
  end

  assign br_take = cw_br & (cond_v ^ cw_inv);
  assign hold    = cw_wait & ~mfc;

  always_comb begin
    if (cw_end)       nxt = '0;
    else if (ir_load) nxt = start_a;
    else if (br_take) nxt = cw_tgt;
    else if (hold)    nxt = upc_q;
    else              nxt = upc_q + UA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= nxt;
  end

  assign ctrl = cw_ctrl;
  assign upc  = upc_q;
  assign uerr = ~cw_ok;
endmodule

module microseq_ctrl_chk #(parameter int UA_W = 6) (
  input logic            clk,
  input logic            rst_n,
  input logic [UA_W-1:0] upc,
  input logic            end_w,
  input logic            ld,
  input logic            br_take,
  input logic            hold,
  input logic [UA_W-1:0] start_a,
  input logic [UA_W-1:0] br_a,
  input logic            uerr
);
  assert_end_to_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_w |=> upc == '0);
  assert_load_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !end_w) |=> upc == $past(start_a));
  assert_branch_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_take && !ld && !end_w) |=> upc == $past(br_a));
  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !br_take && !ld && !end_w) |=> $stable(upc));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !br_take && !ld && !end_w) |=> upc == $past(upc) + UA_W'(1));
  assert_bad_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == '1) |-> uerr);
endmodule

bind microseq_ctrl microseq_ctrl_chk #(.UA_W(UA_W)) chk (
  .clk(clk), .rst_n(rst_n), .upc(upc_q), .end_w(cw_end), .ld(ir_load),
  .br_take(br_take), .hold(hold), .start_a(start_a), .br_a(cw_tgt), .uerr(uerr)
);

// File: tb/microseq_ctrl_test.sv
module microseq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_load = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic        mfc = 1'b1;
  logic        n_flag = 1'b0;
  logic        ext_cond = 1'b0;
  logic [15:0] ctrl;
  logic [5:0]  upc;
  logic        uerr;

  int    mpc = 0;
  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  microseq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .opcode(opcode), .mfc(mfc),
    .n_flag(n_flag), .ext_cond(ext_cond), .ctrl(ctrl), .upc(upc), .uerr(uerr)
  );

  function automatic bit is_valid(int m);
    return (m <= 6) || m == 20 || m == 21 || (m >= 25 && m <= 27) || m == 30 || m == 31;
  endfunction

  function automatic int start_of(int o);
    case (o)
      0: return 3;
      1: return 20;
      2: return 25;
      3: return 30;
      default: return 63;
    endcase
  endfunction

  function automatic int next_of(int m);
    if (m == 6 || m == 21 || m == 27 || m == 31) return 0;
    if (ir_load) return start_of(int'(opcode));
    if (m == 2) return 2;
    if (m == 25 && !n_flag) return 0;
    if (m == 30 && !ext_cond) return 30;
    if ((m == 1 || m == 4) && !mfc) return m;
    return (m + 1) % 64;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mpc <= 0;
    else        mpc <= next_of(mpc);
  end

  always @(negedge clk) begin
    checks++;
    if (int'(upc) != mpc) begin
      fails++;
      $display("FAIL %s upc=%0d expected %0d", tag, upc, mpc);
    end
    checks++;
    if (uerr != !is_valid(mpc)) begin
      fails++;
      $display("FAIL R10 uerr=%0d expected %0d at word %0d", uerr, !is_valid(mpc), mpc);
    end
    if (mpc == 0 || mpc == 5 || mpc == 20 || mpc == 26) begin
      checks++;
      if (ctrl[3] != (mpc == 0)) begin
        fails++;
        $display("FAIL R11 select=%0d expected %0d at word %0d", ctrl[3], mpc == 0, mpc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired in %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_at(int a, int o);
    while (mpc != a) @(negedge clk);
    ir_load = 1'b1;
    opcode  = 4'(o);
    @(negedge clk);
    ir_load = 1'b0;
  endtask

  initial begin
    // R1: reset state
    cycles(3);
    mfc   = 1'b0;
    rst_n = 1'b1;
    tag   = "R3";
    cycles(4);
    mfc = 1'b1;
    tag = "R2";
    cycles(3);
    tag = "R5";
    cycles(3);
    // R4 with R3 wait at word 4 and R8 end at word 6
    tag = "R4";
    load_at(2, 0);
    mfc = 1'b0;
    cycles(4);
    mfc = 1'b1;
    cycles(6);
    tag = "R6";
    n_flag = 1'b0;
    load_at(2, 2);
    cycles(6);
    n_flag = 1'b1;
    load_at(2, 2);
    cycles(8);
    tag = "R8";
    load_at(2, 1);
    cycles(8);
    tag = "R7";
    ext_cond = 1'b0;
    load_at(2, 3);
    cycles(5);
    ext_cond = 1'b1;
    cycles(6);
    tag = "R10";
    load_at(2, 9);
    cycles(8);
    // R9: End beats ir_load, ir_load beats wait, ir_load beats branch
    tag = "R9";
    load_at(2, 0);
    load_at(6, 1);
    mfc = 1'b0;
    load_at(1, 2);
    mfc    = 1'b1;
    n_flag = 1'b0;
    cycles(4);
    load_at(2, 2);
    load_at(25, 0);
    cycles(10);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule